// File: doc/BRIEF.md
# Dual-Image Boot ROM Decoder

This block is purely combinational glue that sits between a 68000-style asynchronous bus and an external 16-bit boot ROM. It watches the upper CPU address lines, the address strobe and the read/write line, and decides when the ROM drives the data bus. It also raises the data acknowledge for that cycle. Two firmware windows are recognised: a high window and a legacy window. A boot-alias select from the system controller also opens the ROM, so that the vector reads at address zero after reset are served from it.

The ROM stores two firmware images of 128K words each. An image-select input drives the top word-address bit of the ROM, and the CPU address lines feed the lower word-address bits shifted down by one. Every enable is gated by the strobe and by read direction. A write into ROM space therefore gets no acknowledge, and the system's bus-error logic takes over.

Top module: `boot_rom_decoder`

## Requirements
- R1: With strobe low and read_i high, any byte address from 0xE00000 to 0xE3FFFF inclusive (byte address = {addr_i, 0}) drives rom_oe_no low.
- R2: With strobe low and read_i high, any byte address from 0xFC0000 to 0xFEFFFF inclusive drives rom_oe_no low.
- R3: With boot_alias_ni high, a byte address outside both windows leaves rom_oe_no and dtack_no high (1 = inactive).
- R4: With boot_alias_ni low, strobe low and read_i high, rom_oe_no is low for every address.
- R5: While as_ni is high, rom_ce_no, rom_oe_no and dtack_no are all high, whatever the other inputs are.
- R6: rom_ce_no equals as_ni in every input state, so the chip enable is never later than the output enable.
- R7: With read_i low (write), rom_oe_no and dtack_no stay high for every address and alias state.
- R8: dtack_no equals rom_oe_no in every input state.
- R9: rom_addr_o[16:0] equals CPU address lines addr_i[17:1], so CPU line n+1 feeds ROM line n.
- R10: rom_addr_o[17] equals img_sel_i, in all states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 23 | CPU address lines A23..A1 |
| as_ni | input | 1 | Address strobe, active low |
| read_i | input | 1 | Bus direction, 1 = read, 0 = write |
| boot_alias_ni | input | 1 | Boot alias select from the system controller, active low |
| img_sel_i | input | 1 | Selects one of the two firmware images |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |
| rom_addr_o | output | 18 | ROM word address; bit 17 is the image select |
| dtack_no | output | 1 | Data acknowledge, active low |

## Verification
The bench probes each window edge from both sides: the last word below the base, the base, the last word inside the window, and the first word past it. An off-by-one comparator, or one that compared the word address against the byte limits, would wrongly open or close the ROM at those points. Every address is driven with both directions, both alias states, both images and both strobe levels. A design that forgot the strobe or direction qualifier would acknowledge idle or write cycles, and one that dropped the alias term would leave the reset vector fetch unanswered. A walking pattern on the address lines shows whether the one-bit shift into the ROM address is wrong, or whether the image bit is crossed with an address line.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;
  localparam int CPU_AW    = 23;              // CPU lines A23..A1
  localparam int BYTE_AW   = CPU_AW + 1;
  localparam int ROM_AW    = 18;              // two images of 128K words
  localparam int IMG_WORDS = ROM_AW - 1;
  localparam int NUM_WIN   = 2;

  localparam logic [BYTE_AW-1:0] WIN_BASE  [NUM_WIN] = '{24'hE0_0000, 24'hFC_0000};
  localparam logic [BYTE_AW-1:0] WIN_LIMIT [NUM_WIN] = '{24'hE3_FFFF, 24'hFE_FFFF};
endpackage

// File: rtl/brd_window_match.sv
module brd_window_match #(
  parameter int            AW    = 23,
  parameter logic [AW:0]   BASE  = '0,
  parameter logic [AW:0]   LIMIT = '1
) (
  input  logic [AW:1] addr_i,
  output logic        hit_o
);
  logic [AW:0] byte_addr;

  always_comb begin
    byte_addr = {addr_i, 1'b0};
    hit_o     = (byte_addr >= BASE) && (byte_addr <= LIMIT);
  end
endmodule

// File: rtl/brd_word_map.sv
module brd_word_map #(
  parameter int ROM_AW = 18
) (
  input  logic [ROM_AW-1:1] cpu_word_i,   // CPU lines A(ROM_AW-1)..A1
  input  logic              img_sel_i,
  output logic [ROM_AW-1:0] rom_addr_o
);
  localparam int IMG_BIT = ROM_AW - 1;

  always_comb begin
    rom_addr_o = {img_sel_i, cpu_word_i};
    a_r10_img_bit: assert (rom_addr_o[IMG_BIT] == img_sel_i)
      else $error("image bit not driven by select");
    a_r9_word_shift: assert (rom_addr_o[1] == cpu_word_i[2])
      else $error("CPU A2 not on ROM A1");
  end
endmodule

// File: rtl/brd_strobe_gate.sv
module brd_strobe_gate (
  input  logic as_ni,
  input  logic read_i,
  input  logic win_hit_i,
  input  logic boot_alias_ni,
  output logic rom_ce_no,
  output logic rom_oe_no,
  output logic dtack_no
);
  logic rom_sel;

  always_comb begin
    rom_sel   = win_hit_i || !boot_alias_ni;
    rom_ce_no = as_ni;
    rom_oe_no = !(!as_ni && read_i && rom_sel);
    dtack_no  = as_ni || !read_i || !rom_sel;

    if (as_ni) begin
      a_r5_idle_quiet: assert (rom_ce_no && rom_oe_no && dtack_no)
        else $error("decode active without strobe");
    end
    if (!read_i) begin
      a_r7_write_blocked: assert (rom_oe_no && dtack_no)
        else $error("ROM enabled on write");
    end
    if (!as_ni && read_i && !boot_alias_ni) begin
      a_r4_alias_read: assert (!rom_oe_no)
        else $error("alias read not enabled");
    end
    if (!rom_oe_no) begin
      a_r6_ce_first: assert (!rom_ce_no)
        else $error("output enable without chip enable");
    end
  end
endmodule

// File: rtl/boot_rom_decoder.sv
module boot_rom_decoder
  import boot_rom_pkg::*;
(
  input  logic [CPU_AW:1]   addr_i,
  input  logic              as_ni,
  input  logic              read_i,
  input  logic              boot_alias_ni,
  input  logic              img_sel_i,
  output logic              rom_ce_no,
  output logic              rom_oe_no,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              dtack_no
);
  logic [NUM_WIN-1:0] win_hit;
  logic               any_hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    brd_window_match #(
      .AW   (CPU_AW),
      .BASE (WIN_BASE[w]),
      .LIMIT(WIN_LIMIT[w])
    ) u_match (
      .addr_i(addr_i),
      .hit_o (win_hit[w])
    );
  end

  assign any_hit = |win_hit;

  brd_strobe_gate u_gate (
    .as_ni        (as_ni),
    .read_i       (read_i),
    .win_hit_i    (any_hit),
    .boot_alias_ni(boot_alias_ni),
    .rom_ce_no    (rom_ce_no),
    .rom_oe_no    (rom_oe_no),
    .dtack_no     (dtack_no)
  );

  brd_word_map #(.ROM_AW(ROM_AW)) u_map (
    .cpu_word_i(addr_i[ROM_AW-1:1]),
    .img_sel_i (img_sel_i),
    .rom_addr_o(rom_addr_o)
  );

  always_comb begin
    a_r3_win_exclusive: assert (!(win_hit[0] && win_hit[1]))
      else $error("windows overlap");
    if (!as_ni && read_i && boot_alias_ni && !any_hit) begin
      a_r3_outside_quiet: assert (rom_oe_no && dtack_no)
        else $error("ROM enabled outside windows");
    end
  end
endmodule

// File: tb/sim_boot_rom_decoder.sv
`timescale 1ns/1ps
module sim_boot_rom_decoder;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [23:1] addr_i;
  logic        as_ni, read_i, boot_alias_ni, img_sel_i;
  logic        rom_ce_no, rom_oe_no, dtack_no;
  logic [17:0] rom_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  boot_rom_decoder u0 (
    .addr_i(addr_i), .as_ni(as_ni), .read_i(read_i),
    .boot_alias_ni(boot_alias_ni), .img_sel_i(img_sel_i),
    .rom_ce_no(rom_ce_no), .rom_oe_no(rom_oe_no),
    .rom_addr_o(rom_addr_o), .dtack_no(dtack_no)
  );

  function automatic bit in_win(logic [23:0] b);
    return (b >= 24'hE00000 && b <= 24'hE3FFFF) || (b >= 24'hFC0000 && b <= 24'hFEFFFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one vector, sample at the following falling edge
  task automatic apply(logic [23:0] byte_a, bit as_n, bit rd, bit al_n, bit img, string oe_req);
    logic exp_oe;
    @(posedge clk);
    addr_i = byte_a[23:1]; as_ni = as_n; read_i = rd;
    boot_alias_ni = al_n; img_sel_i = img;
    @(negedge clk);
    exp_oe = !(!as_n && rd && (!al_n || in_win(byte_a)));
    chk(oe_req, {31'd0, rom_oe_no}, {31'd0, exp_oe});
    chk("R8", {31'd0, dtack_no}, {31'd0, exp_oe});
    chk("R6", {31'd0, rom_ce_no}, {31'd0, as_n});
    chk("R9", {15'd0, rom_addr_o[16:0]}, {15'd0, byte_a[17:1]});
    chk("R10", {31'd0, rom_addr_o[17]}, {31'd0, img});
  endtask

  task automatic t_idle();
    apply(24'hE00000, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    apply(24'hFC0000, 1'b1, 1'b1, 1'b1, 1'b1, "R5");
    apply(24'h000000, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_edges(logic [23:0] base, logic [23:0] last, string req);
    logic [23:0] pts [6];
    pts = '{base - 24'd2, base, base + 24'd2, last - 24'd1, last + 24'd1, last - 24'd3};
    foreach (pts[i])
      for (int k = 0; k < 16; k++)
        apply(pts[i], k[0], k[1], k[2], k[3],
              (k[0] ? "R5" : (!k[1] ? "R7" : (!k[2] ? "R4" : req))));
  endtask

  task automatic t_outside();
    logic [23:0] pts [5];
    pts = '{24'h000000, 24'hE40000, 24'hFBFFFE, 24'hFF0000, 24'h7FFFFE};
    foreach (pts[i]) begin
      apply(pts[i], 1'b0, 1'b1, 1'b1, 1'b0, "R3");
      apply(pts[i], 1'b0, 1'b1, 1'b0, 1'b1, "R4");
      apply(pts[i], 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    end
  endtask

  task automatic t_walk();
    for (int b = 1; b < 24; b++) begin
      apply(24'd1 << b, 1'b0, 1'b1, 1'b1, b[0], "R3");
      apply(~(24'd1 << b) & 24'hFFFFFE, 1'b0, 1'b1, 1'b1, ~b[0], "R3");
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [23:0] a;
      logic [3:0]  k;
      a = {$urandom_range(0, 32'hFF), $urandom_range(0, 32'hFFFF)} & 24'hFFFFFE;
      k = 4'($urandom_range(0, 15));
      apply(a, k[0], k[1], k[2], k[3],
            (k[0] ? "R5" : (!k[1] ? "R7" : (!k[2] ? "R4" : "R1R2R3"))));
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    addr_i = '0; as_ni = 1'b1; read_i = 1'b1; boot_alias_ni = 1'b1; img_sel_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5", {29'd0, rom_ce_no, rom_oe_no, dtack_no}, 32'd7);   // reset-time idle
    t_idle();
    t_edges(24'hE00000, 24'hE3FFFF, "R1");
    t_edges(24'hFC0000, 24'hFEFFFF, "R2");
    t_outside();
    t_walk();
    t_random();
    report();
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule